// File: doc/BRIEF.md
# Universal Bus Transceiver Data Path

This block carries data in both directions between two buses, A and B. Each direction has its own storage for every half of the word. Per half, the storage acts as a transparent latch, as a static hold, or as a rising-edge register. The latch-enable and direction-clock inputs pick the behaviour in each system-clock cycle. An active-low output enable per direction decides whether the far bus is driven. Each bus output is given as a data value plus a per-bit drive enable, so pad logic outside the block can build the tri-state pins.

The word is split into halves, nine bits each by default. In split mode every half takes its own set of controls. In wide mode the controls of half 0 govern every half and the other control bits are ignored.

All control inputs are sampled on the system clock. A direction clock that is sampled low and then high on consecutive system edges counts as its rising edge.

A test-mode input hands both bus outputs to override inputs coming from boundary test logic. While test mode is high, the stored values are frozen.

The buses are plain, level-driven wires with no flow control. For that reason neither side has a valid/ready handshake, and no back-pressure applies.

Top module: `ubt_datapath`

## Requirements
- R1: With the A-to-B latch enable of a half high and test mode low, the B output of that half equals the A input sampled at the previous system-clock edge.
- R2: With the latch enable low and the direction clock not rising, the stored value and the B output do not change, whatever the A input does.
- R3: With the latch enable low, a direction clock sampled 0 at one system edge and 1 at the next captures the A input sampled at that second edge. A clock that stays high or falls captures nothing.
- R4: The output enable is registered. One cycle after the active-low enable of a half is sampled low, every drive-enable bit of that half's B output is 1. One cycle after it is sampled high, every such bit is 0.
- R5: The B-to-A direction obeys R1 to R4 using its own latch enable, clock and output enable, driving the A output from the B input.
- R6: While reset is asserted and for the first cycle after it, both stored values are 0 and no drive enable is set. The clock edge detector resets as if both direction clocks were high, so a clock held high through reset is not a rising edge.
- R7: With wide mode low (split mode), half h uses control bit h of every control vector, independently of the other halves.
- R8: With wide mode high, every half uses control bit 0 of every control vector. Changes on the other control bits have no effect on the outputs.
- R9: With test mode high, in the same cycle, the A and B data outputs equal the A and B override data inputs, and the drive enables equal the A and B override drive inputs.
- R10: While test mode is high, no capture takes place. After test mode falls, the outputs show the values stored before test mode rose, until a new capture occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all controls are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wide_mode | input | 1 | 1: half 0 controls govern all halves; 0: per-half controls |
| test_mode | input | 1 | 1: outputs taken from the override inputs, storage frozen |
| a_in | input | 18 | Value seen on bus A |
| b_in | input | 18 | Value seen on bus B |
| ab_oe_n | input | 2 | Active-low B output enable, one bit per half |
| ab_le | input | 2 | A-to-B latch enable, one bit per half |
| ab_clk | input | 2 | A-to-B direction clock, one bit per half |
| ba_oe_n | input | 2 | Active-low A output enable, one bit per half |
| ba_le | input | 2 | B-to-A latch enable, one bit per half |
| ba_clk | input | 2 | B-to-A direction clock, one bit per half |
| tst_a_data | input | 18 | Override data for bus A in test mode |
| tst_a_drive | input | 18 | Override drive enable for bus A in test mode |
| tst_b_data | input | 18 | Override data for bus B in test mode |
| tst_b_drive | input | 18 | Override drive enable for bus B in test mode |
| a_out | output | 18 | Data presented to bus A |
| a_drv | output | 18 | Per-bit drive enable for bus A |
| b_out | output | 18 | Data presented to bus B |
| b_drv | output | 18 | Per-bit drive enable for bus B |

## Verification
Some properties are checked on every cycle: transparent following, holding while the clock is static, capture on a sampled rising edge, the registered drive enable of half 0, the upper half mirroring the lower one in wide mode, and the test override. Other behaviour can only be shown by the bench's scenarios, which compare against a cycle model computed from the requirements. These cover the reset state and the freezing of storage across a test-mode window with old values coming back. They also cover the independence of the halves in split mode and the fact that upper-half controls are ignored in wide mode. A sweep of data patterns is run through each mode.

// File: rtl/ubt_pkg.sv
package ubt_pkg;
  // Per-half control after mode selection and edge detection
  typedef struct packed {
    logic le;    // transparent request
    logic rise;  // direction clock rose between two system edges
    logic oe;    // active-high output enable
  } lane_ctl_t;
endpackage

// File: rtl/ubt_ctrl_sel.sv
module ubt_ctrl_sel
  import ubt_pkg::*;
#(
  parameter int NUM_HALVES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wide_mode,
  input  logic [NUM_HALVES-1:0] oe_n_i,
  input  logic [NUM_HALVES-1:0] le_i,
  input  logic [NUM_HALVES-1:0] dclk_i,
  output lane_ctl_t [NUM_HALVES-1:0] ctl_o
);
  logic [NUM_HALVES-1:0] dclk_prev;
  logic [NUM_HALVES-1:0] dclk_rise;

  // Reset as if high: a clock held high through reset is no edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dclk_prev <= '1;
    else        dclk_prev <= dclk_i;
  end

  assign dclk_rise = dclk_i & ~dclk_prev;

  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_sel
    localparam int SRC_WIDE = 0;
    always_comb begin
      if (wide_mode) begin
        ctl_o[h].le   = le_i[SRC_WIDE];
        ctl_o[h].rise = dclk_rise[SRC_WIDE];
        ctl_o[h].oe   = ~oe_n_i[SRC_WIDE];
      end else begin
        ctl_o[h].le   = le_i[h];
        ctl_o[h].rise = dclk_rise[h];
        ctl_o[h].oe   = ~oe_n_i[h];
      end
    end
  end
endmodule

// File: rtl/ubt_lane.sv
module ubt_lane
  import ubt_pkg::*;
#(
  parameter int HALF_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              freeze,
  input  lane_ctl_t         ctl,
  input  logic [HALF_W-1:0] d_in,
  output logic [HALF_W-1:0] q_o,
  output logic [HALF_W-1:0] drv_o
);
  logic oe_q;
  logic capture;

  assign capture = !freeze && (ctl.le || ctl.rise);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_o  <= '0;
      oe_q <= 1'b0;
    end else begin
      if (capture) q_o <= d_in;
      oe_q <= ctl.oe;
    end
  end

  assign drv_o = {HALF_W{oe_q}};
endmodule

// File: rtl/ubt_out_ovr.sv
module ubt_out_ovr #(
  parameter int WIDTH = 18
) (
  input  logic             test_mode,
  input  logic [WIDTH-1:0] norm_data,
  input  logic [WIDTH-1:0] norm_drv,
  input  logic [WIDTH-1:0] ovr_data,
  input  logic [WIDTH-1:0] ovr_drv,
  output logic [WIDTH-1:0] out_data,
  output logic [WIDTH-1:0] out_drv
);
  always_comb begin
    if (test_mode) begin
      out_data = ovr_data;
      out_drv  = ovr_drv;
    end else begin
      out_data = norm_data;
      out_drv  = norm_drv;
    end
  end
endmodule

// File: rtl/ubt_datapath.sv
module ubt_datapath
  import ubt_pkg::*;
#(
  parameter int HALF_W     = 9,
  parameter int NUM_HALVES = 2,
  localparam int W         = HALF_W * NUM_HALVES
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wide_mode,
  input  logic                  test_mode,
  input  logic [W-1:0]          a_in,
  input  logic [W-1:0]          b_in,
  input  logic [NUM_HALVES-1:0] ab_oe_n,
  input  logic [NUM_HALVES-1:0] ab_le,
  input  logic [NUM_HALVES-1:0] ab_clk,
  input  logic [NUM_HALVES-1:0] ba_oe_n,
  input  logic [NUM_HALVES-1:0] ba_le,
  input  logic [NUM_HALVES-1:0] ba_clk,
  input  logic [W-1:0]          tst_a_data,
  input  logic [W-1:0]          tst_a_drive,
  input  logic [W-1:0]          tst_b_data,
  input  logic [W-1:0]          tst_b_drive,
  output logic [W-1:0]          a_out,
  output logic [W-1:0]          a_drv,
  output logic [W-1:0]          b_out,
  output logic [W-1:0]          b_drv
);
  lane_ctl_t [NUM_HALVES-1:0] ab_ctl;
  lane_ctl_t [NUM_HALVES-1:0] ba_ctl;
  logic [W-1:0] ab_q, ab_d;
  logic [W-1:0] ba_q, ba_d;

  ubt_ctrl_sel #(.NUM_HALVES(NUM_HALVES)) ab_sel_i (
    .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode),
    .oe_n_i(ab_oe_n), .le_i(ab_le), .dclk_i(ab_clk), .ctl_o(ab_ctl)
  );

  ubt_ctrl_sel #(.NUM_HALVES(NUM_HALVES)) ba_sel_i (
    .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode),
    .oe_n_i(ba_oe_n), .le_i(ba_le), .dclk_i(ba_clk), .ctl_o(ba_ctl)
  );

  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
    ubt_lane #(.HALF_W(HALF_W)) ab_lane_i (
      .clk(clk), .rst_n(rst_n), .freeze(test_mode), .ctl(ab_ctl[h]),
      .d_in(a_in[h*HALF_W +: HALF_W]),
      .q_o(ab_q[h*HALF_W +: HALF_W]),
      .drv_o(ab_d[h*HALF_W +: HALF_W])
    );
    ubt_lane #(.HALF_W(HALF_W)) ba_lane_i (
      .clk(clk), .rst_n(rst_n), .freeze(test_mode), .ctl(ba_ctl[h]),
      .d_in(b_in[h*HALF_W +: HALF_W]),
      .q_o(ba_q[h*HALF_W +: HALF_W]),
      .drv_o(ba_d[h*HALF_W +: HALF_W])
    );
  end

  ubt_out_ovr #(.WIDTH(W)) b_ovr_i (
    .test_mode(test_mode), .norm_data(ab_q), .norm_drv(ab_d),
    .ovr_data(tst_b_data), .ovr_drv(tst_b_drive),
    .out_data(b_out), .out_drv(b_drv)
  );

  ubt_out_ovr #(.WIDTH(W)) a_ovr_i (
    .test_mode(test_mode), .norm_data(ba_q), .norm_drv(ba_d),
    .ovr_data(tst_a_data), .ovr_drv(tst_a_drive),
    .out_data(a_out), .out_drv(a_drv)
  );
endmodule

// File: rtl/ubt_datapath_chk.sv
module ubt_datapath_chk #(
  parameter int HALF_W     = 9,
  parameter int NUM_HALVES = 2,
  localparam int W         = HALF_W * NUM_HALVES,
  localparam int L         = HALF_W
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  wide_mode,
  input logic                  test_mode,
  input logic [W-1:0]          a_in,
  input logic [W-1:0]          b_in,
  input logic [NUM_HALVES-1:0] ab_oe_n,
  input logic [NUM_HALVES-1:0] ab_le,
  input logic [NUM_HALVES-1:0] ab_clk,
  input logic [NUM_HALVES-1:0] ba_oe_n,
  input logic [NUM_HALVES-1:0] ba_le,
  input logic [NUM_HALVES-1:0] ba_clk,
  input logic [W-1:0]          tst_a_data,
  input logic [W-1:0]          tst_a_drive,
  input logic [W-1:0]          tst_b_data,
  input logic [W-1:0]          tst_b_drive,
  input logic [W-1:0]          a_out,
  input logic [W-1:0]          a_drv,
  input logic [W-1:0]          b_out,
  input logic [W-1:0]          b_drv
);
  a_r1_ab_transparent: assert property (@(posedge clk) disable iff (!rst_n)
    (ab_le[0] && !test_mode) |=> (test_mode || b_out[L-1:0] == $past(a_in[L-1:0])));

  a_r2_ab_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ab_le[0] && !test_mode && !(ab_clk[0] && !$past(ab_clk[0])))
      |=> (test_mode || $stable(b_out[L-1:0])));

  a_r3_ab_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (!ab_le[0] && !test_mode && $past(rst_n) && ab_clk[0] && !$past(ab_clk[0]))
      |=> (test_mode || b_out[L-1:0] == $past(a_in[L-1:0])));

  a_r4_ab_drive_on: assert property (@(posedge clk) disable iff (!rst_n)
    !ab_oe_n[0] |=> (test_mode || b_drv[L-1:0] == {L{1'b1}}));

  a_r4_ab_drive_off: assert property (@(posedge clk) disable iff (!rst_n)
    ab_oe_n[0] |=> (test_mode || b_drv[L-1:0] == '0));

  a_r5_ba_transparent: assert property (@(posedge clk) disable iff (!rst_n)
    (ba_le[0] && !test_mode) |=> (test_mode || a_out[L-1:0] == $past(b_in[L-1:0])));

  a_r7_split_upper: assert property (@(posedge clk) disable iff (!rst_n)
    (!wide_mode && ab_le[NUM_HALVES-1] && !test_mode)
      |=> (test_mode || b_out[W-1 -: L] == $past(a_in[W-1 -: L])));

  a_r8_wide_drive_match: assert property (@(posedge clk) disable iff (!rst_n)
    (wide_mode && !test_mode) |=> (test_mode || b_drv[W-1 -: L] == b_drv[L-1:0]));

  a_r9_test_override: assert property (@(posedge clk) disable iff (!rst_n)
    test_mode |-> (b_out == tst_b_data && b_drv == tst_b_drive &&
                   a_out == tst_a_data && a_drv == tst_a_drive));
endmodule

bind ubt_datapath ubt_datapath_chk #(.HALF_W(HALF_W), .NUM_HALVES(NUM_HALVES)) chk_i (.*);

// File: tb/ubt_datapath_tb_top.sv
module ubt_datapath_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HW = 9;
  localparam int NH = 2;
  localparam int W  = HW * NH;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wide_mode = 1'b0, test_mode = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [NH-1:0] ab_oe_n = '1, ab_le = '0, ab_clk = '0;
  logic [NH-1:0] ba_oe_n = '1, ba_le = '0, ba_clk = '0;
  logic [W-1:0] tst_a_data = '0, tst_a_drive = '0, tst_b_data = '0, tst_b_drive = '0;
  logic [W-1:0] a_out, a_drv, b_out, b_drv;

  int n_checks = 0;
  int n_fail = 0;

  // bench model, built from the requirements
  logic [W-1:0] m_ab = '0, m_ba = '0;
  logic [NH-1:0] m_prev_ab = '1, m_prev_ba = '1;
  logic [NH-1:0] m_oe_ab = '0, m_oe_ba = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ubt_datapath #(.HALF_W(HW), .NUM_HALVES(NH)) dut_i (
    .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode), .test_mode(test_mode),
    .a_in(a_in), .b_in(b_in),
    .ab_oe_n(ab_oe_n), .ab_le(ab_le), .ab_clk(ab_clk),
    .ba_oe_n(ba_oe_n), .ba_le(ba_le), .ba_clk(ba_clk),
    .tst_a_data(tst_a_data), .tst_a_drive(tst_a_drive),
    .tst_b_data(tst_b_data), .tst_b_drive(tst_b_drive),
    .a_out(a_out), .a_drv(a_drv), .b_out(b_out), .b_drv(b_drv)
  );

  function automatic logic [W-1:0] pat(int i);
    return W'((i * 40503 + 12345) ^ (i << 5));
  endfunction

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    logic [W-1:0] eb, ebd, ea, ead;
    for (int h = 0; h < NH; h++) begin
      ebd[h*HW +: HW] = {HW{m_oe_ab[h]}};
      ead[h*HW +: HW] = {HW{m_oe_ba[h]}};
    end
    eb = m_ab; ea = m_ba;
    if (test_mode) begin
      eb = tst_b_data; ebd = tst_b_drive; ea = tst_a_data; ead = tst_a_drive;
    end
    chk({tag, " b_out"}, b_out, eb);
    chk({tag, " b_drv"}, b_drv, ebd);
    chk({tag, " a_out"}, a_out, ea);
    chk({tag, " a_drv"}, a_drv, ead);
  endtask

  // one system cycle: inputs already driven at a falling edge
  task automatic cycle(string tag);
    @(posedge clk);
    if (rst_n) begin
      for (int h = 0; h < NH; h++) begin
        int c;
        c = wide_mode ? 0 : h;
        if (!test_mode && (ab_le[c] || (ab_clk[c] && !m_prev_ab[c])))
          m_ab[h*HW +: HW] = a_in[h*HW +: HW];
        if (!test_mode && (ba_le[c] || (ba_clk[c] && !m_prev_ba[c])))
          m_ba[h*HW +: HW] = b_in[h*HW +: HW];
        m_oe_ab[h] = ~ab_oe_n[c];
        m_oe_ba[h] = ~ba_oe_n[c];
      end
      m_prev_ab = ab_clk;
      m_prev_ba = ba_clk;
    end
    @(negedge clk);
    check_all(tag);
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [W-1:0] snap_b, snap_a;
    // R6: reset state
    repeat (3) @(negedge clk);
    check_all("R6 in reset");
    rst_n = 1'b1;
    cycle("R6 after reset");

    // R1 / R4 / R8: wide mode transparent sweep, both enables on
    wide_mode = 1'b1; ab_le = 2'b01; ab_oe_n = 2'b10; ba_le = 2'b01; ba_oe_n = 2'b10;
    for (int i = 0; i < 40; i++) begin
      a_in = pat(i); b_in = pat(i + 100);
      cycle("R1 R5 R8 transparent");
    end

    // R2: hold while clock static, A toggles
    ab_le = '0; ba_le = '0;
    cycle("R2 settle");
    snap_b = b_out; snap_a = a_out;
    for (int i = 0; i < 20; i++) begin
      a_in = ~a_in ^ pat(i); b_in = pat(i + 7);
      ab_clk = (i < 10) ? 2'b00 : 2'b10;  // upper clock ignored in wide mode (R8)
      cycle("R2 R8 hold");
    end
    chk("R2 b held", b_out, snap_b);
    chk("R5 a held", a_out, snap_a);

    // R3: rising edge captures, high and falling do not
    ab_clk = '0;
    for (int i = 0; i < 12; i++) begin
      a_in = pat(i + 300); b_in = pat(i + 400);
      ab_clk[0] = i[1]; ba_clk[0] = i[2];
      cycle("R3 R5 edge capture");
    end

    // R4: output enable toggling
    for (int i = 0; i < 8; i++) begin
      ab_oe_n = i[1:0]; ba_oe_n = ~i[1:0];
      cycle("R4 R5 output enable");
    end

    // R7: split mode, halves independent
    wide_mode = 1'b0; ab_clk = '0; ba_clk = '0;
    for (int i = 0; i < 24; i++) begin
      ab_le = i[1:0]; ba_le = i[2:1]; ab_oe_n = i[3:2]; ba_oe_n = i[2:1];
      ab_clk = i[3:2]; ba_clk = {i[0], i[3]};
      a_in = pat(i + 500); b_in = pat(i + 600);
      cycle("R7 split");
    end

    // R9 / R10: test override, storage frozen
    ab_le = '0; ba_le = '0; ab_clk = '0; ba_clk = '0; ab_oe_n = '0; ba_oe_n = '0;
    cycle("R10 settle");
    snap_b = b_out; snap_a = a_out;
    test_mode = 1'b1;
    for (int i = 0; i < 10; i++) begin
      ab_le = '1; ba_le = '1; ab_clk = i[0] ? '1 : '0;
      a_in = pat(i + 700); b_in = pat(i + 800);
      tst_b_data = pat(i + 900); tst_b_drive = pat(i + 950);
      tst_a_data = pat(i + 1000); tst_a_drive = pat(i + 1050);
      #1;
      chk("R9 b override", b_out, tst_b_data);
      chk("R9 a drive override", a_drv, tst_a_drive);
      cycle("R9 R10 test mode");
    end
    ab_le = '0; ba_le = '0; ab_clk = '1; ba_clk = '0;
    test_mode = 1'b0;
    #1;
    chk("R10 b restored", b_out, snap_b);
    chk("R10 a restored", a_out, snap_a);
    cycle("R10 after test");
    chk("R10 b still old", b_out, snap_b);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule